// File: doc/BRIEF.md
# Write-Back L2 Line Controller with Parked-Request Replay

This block holds the per-line control state of a small write-back second-level cache. It serves loads, stores and atomics that arrive one per cycle from an upstream port. A line is clean, fully modified, partially dirty, or waiting for its write-back to be acknowledged. When a request needs the dirty data pushed to memory first, the block issues a write-back and moves the line into the waiting state. It then parks the request in a small per-address stall buffer and takes it off the input at once. The request is only acted on after the memory side acknowledges that write-back.

Any other request that reaches a line in the waiting state joins the same parked queue. It is not retried. When the acknowledge arrives, the line becomes clean. The parked requests for that address then replay one per cycle in arrival order, and new input is held off until they finish. A replayed load is answered, and a replayed atomic or cache-bypassing store is passed downstream. Two bypass flags travel with each request and are returned with its response. One flag tells the upstream level not to keep the data. The other keeps the request out of this cache as well.

Top module: `l2lc_ctrl`

## Requirements
- R1: After reset every line is clean, `req_ready` is 1 and `wb_valid`, `fwd_valid` and `resp_valid` are 0.
- R2: A load (`req_op`=0) on a clean or fully modified line produces exactly one `resp_valid` pulse, in the cycle after acceptance, with the request's id and address. The line state is left unchanged.
- R3: A load on a partially dirty line produces a `wb_valid` pulse for that address in the cycle after acceptance and no response. The line enters the waiting state.
- R4: An atomic (`req_op`=2), or a store (`req_op`=1) with `req_sys_bypass`=1, is forwarded on `fwd_valid`/`fwd_op` (echoing `req_op`) in the cycle after acceptance if the line is clean, and the line stays clean. If the line is modified or dirty, a write-back is issued instead.
- R5: A request that triggered a write-back produces no response and no forward before the matching `wb_ack` has been seen.
- R6: Any request that reaches a line in the waiting state is accepted, produces no output, and is parked.
- R7: In the cycle after `wb_ack`, `req_ready` is 0. Parked requests of that address replay one per cycle, starting one cycle after the acknowledge, in arrival order.
- R8: The acknowledge makes the line clean before replay. A replayed load is therefore answered and a replayed atomic forwarded, with no second write-back.
- R9: If a replayed store makes the line dirty and a later parked load meets it, that load issues a new write-back and stays parked. Replay of that address stops until the next acknowledge.
- R10: `req_ready` is 0 while every stall slot holds an address or any slot holds DEPTH requests.
- R11: A normal store (`req_op`=1, `req_sys_bypass`=0) is answered in the cycle after acceptance. The line becomes fully modified when `req_full`=1 and partially dirty when `req_full`=0.
- R12: A response carries `resp_l1_nocache` = `req_l1_bypass` OR `req_sys_bypass`, and `resp_l2_nocache` = `req_sys_bypass`, of the request answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 0 load, 1 store, 2 atomic |
| req_addr | input | AW | Line index |
| req_id | input | IDW | Requester tag |
| req_full | input | 1 | Store covers the whole line |
| req_l1_bypass | input | 1 | Upstream level must not keep the line |
| req_sys_bypass | input | 1 | Neither level keeps the line |
| wb_valid | output | 1 | Write-back issued |
| wb_addr | output | AW | Line written back |
| wb_ack | input | 1 | Write-back acknowledged |
| wb_ack_addr | input | AW | Line whose write-back completed |
| fwd_valid | output | 1 | Request sent downstream |
| fwd_addr | output | AW | Forwarded line |
| fwd_id | output | IDW | Forwarded tag |
| fwd_op | output | 2 | Forwarded operation code |
| resp_valid | output | 1 | Response to upstream |
| resp_addr | output | AW | Responded line |
| resp_id | output | IDW | Responded tag |
| resp_l1_nocache | output | 1 | Upstream must not keep the data |
| resp_l2_nocache | output | 1 | Request bypassed this cache |

## Verification
The checks assume that `wb_ack` only names a line that is waiting for its write-back and arrives at most once per write-back. They also assume that `req_valid` is held only while the requester honours `req_ready`. The bench drives each acknowledge itself, only after it has observed the matching `wb_valid`, and it raises a request only after it has seen `req_ready` high at the falling edge. The sweep resets before every combination of starting line state, operation and bypass flags, so that each combination starts from a known line.

// File: rtl/l2lc_pkg.sv
package l2lc_pkg;

  typedef enum logic [1:0] {
    LN_CLEAN  = 2'd0,
    LN_MOD    = 2'd1,
    LN_DIRTY  = 2'd2,
    LN_WAITWB = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    ACT_RESP = 2'd0,
    ACT_FWD  = 2'd1,
    ACT_WB   = 2'd2,
    ACT_PARK = 2'd3
  } act_e;

  localparam logic [1:0] OPC_LOAD   = 2'd0;
  localparam logic [1:0] OPC_STORE  = 2'd1;
  localparam logic [1:0] OPC_ATOMIC = 2'd2;

  // parked entry layout: {id, op, full, l1_bypass, sys_bypass}
  localparam int FLAG_BITS = 5;

endpackage

// File: rtl/l2lc_decide.sv
module l2lc_decide
  import l2lc_pkg::*;
(
  input  logic [1:0] op,
  input  logic       full,
  input  logic       sysb,
  input  line_st_e   st,
  output act_e       act,
  output line_st_e   nst
);

  logic goes_down;

  always_comb begin
    goes_down = (op == OPC_ATOMIC) || (op == OPC_STORE && sysb);
    act = ACT_RESP;
    nst = st;
    if (st == LN_WAITWB) begin
      act = ACT_PARK;
    end else if (goes_down) begin
      if (st == LN_CLEAN) act = ACT_FWD;
      else begin
        act = ACT_WB;
        nst = LN_WAITWB;
      end
    end else if (op == OPC_STORE) begin
      act = ACT_RESP;
      nst = full ? LN_MOD : LN_DIRTY;
    end else if (st == LN_DIRTY) begin
      act = ACT_WB;
      nst = LN_WAITWB;
    end
  end

endmodule

// File: rtl/l2lc_line_tbl.sv
module l2lc_line_tbl
  import l2lc_pkg::*;
#(
  parameter int AW = 4,
  localparam int NLINES = 1 << AW
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  line_st_e      wr_st,
  input  logic          ack_en,
  input  logic [AW-1:0] ack_addr,
  output line_st_e      st_o [NLINES]
);

  line_st_e st [NLINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) st[i] <= LN_CLEAN;
    end else begin
      if (wr_en)  st[wr_addr]  <= wr_st;
      if (ack_en) st[ack_addr] <= LN_CLEAN;
    end
  end

  always_comb begin
    for (int i = 0; i < NLINES; i++) st_o[i] = st[i];
  end

  AST_ACK_WAITING: assert property (@(posedge clk) disable iff (rst)
    ack_en |-> st[ack_addr] == LN_WAITWB); // R8
  AST_WR_ACK_APART: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ack_en) |-> wr_addr != ack_addr); // R8

endmodule

// File: rtl/l2lc_stall_buf.sv
module l2lc_stall_buf #(
  parameter int AW    = 4,
  parameter int NSLOT = 4,
  parameter int DEPTH = 4,
  parameter int RW    = 9,
  localparam int SW = $clog2(NSLOT),
  localparam int DW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_addr,
  output logic          any_free,
  output logic          any_full,
  input  logic          push_en,
  input  logic [RW-1:0] push_data,
  input  logic          ack_en,
  input  logic [AW-1:0] ack_addr,
  output logic          rp_valid,
  output logic [AW-1:0] rp_addr,
  output logic [RW-1:0] rp_data,
  input  logic          rp_pop,
  input  logic          rp_stop
);

  logic [NSLOT-1:0] s_v, s_d;
  logic [AW-1:0]    s_a [NSLOT];
  logic [DW-1:0]    s_h [NSLOT];
  logic [DW-1:0]    s_t [NSLOT];
  logic [CW-1:0]    s_c [NSLOT];
  logic [RW-1:0]    mem [NSLOT*DEPTH];

  logic          lk_hit, ack_hit;
  logic [SW-1:0] lk_idx, free_idx, ack_idx, rp_sel, push_idx;

  always_comb begin
    lk_hit = 1'b0; lk_idx = '0; any_free = 1'b0; free_idx = '0;
    ack_hit = 1'b0; ack_idx = '0; any_full = 1'b0;
    rp_valid = 1'b0; rp_sel = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (s_v[i] && s_a[i] == lk_addr) begin lk_hit = 1'b1; lk_idx = SW'(i); end
      if (!s_v[i]) begin any_free = 1'b1; free_idx = SW'(i); end
      if (s_v[i] && s_a[i] == ack_addr) begin ack_hit = 1'b1; ack_idx = SW'(i); end
      if (s_v[i] && s_c[i] == CW'(DEPTH)) any_full = 1'b1;
      if (s_d[i]) begin rp_valid = 1'b1; rp_sel = SW'(i); end
    end
    push_idx = lk_hit ? lk_idx : free_idx;
    rp_addr  = s_a[rp_sel];
    rp_data  = mem[{rp_sel, s_h[rp_sel]}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v <= '0;
      s_d <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        s_a[i] <= '0; s_h[i] <= '0; s_t[i] <= '0; s_c[i] <= '0;
      end
    end else begin
      if (push_en) begin
        if (!lk_hit) begin
          s_v[push_idx] <= 1'b1;
          s_a[push_idx] <= lk_addr;
        end
        s_t[push_idx] <= s_t[push_idx] + 1'b1;
        s_c[push_idx] <= s_c[push_idx] + 1'b1;
      end
      if (ack_en && ack_hit) s_d[ack_idx] <= 1'b1;
      if (rp_pop) begin
        s_h[rp_sel] <= s_h[rp_sel] + 1'b1;
        s_c[rp_sel] <= s_c[rp_sel] - 1'b1;
        if (s_c[rp_sel] == CW'(1)) begin
          s_v[rp_sel] <= 1'b0;
          s_d[rp_sel] <= 1'b0;
        end
      end
      if (rp_stop) s_d[rp_sel] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) mem[{push_idx, s_t[push_idx]}] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push_en |-> (lk_hit ? (s_c[lk_idx] < CW'(DEPTH)) : any_free)); // R10
  AST_POP_HAS_HEAD: assert property (@(posedge clk) disable iff (rst)
    rp_pop |-> (rp_valid && s_c[rp_sel] != '0)); // R7

endmodule

// File: rtl/l2lc_ctrl.sv
module l2lc_ctrl
  import l2lc_pkg::*;
#(
  parameter int AW    = 4,
  parameter int IDW   = 4,
  parameter int NSLOT = 4,
  parameter int DEPTH = 4
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_op,
  input  logic [AW-1:0]  req_addr,
  input  logic [IDW-1:0] req_id,
  input  logic           req_full,
  input  logic           req_l1_bypass,
  input  logic           req_sys_bypass,
  output logic           wb_valid,
  output logic [AW-1:0]  wb_addr,
  input  logic           wb_ack,
  input  logic [AW-1:0]  wb_ack_addr,
  output logic           fwd_valid,
  output logic [AW-1:0]  fwd_addr,
  output logic [IDW-1:0] fwd_id,
  output logic [1:0]     fwd_op,
  output logic           resp_valid,
  output logic [AW-1:0]  resp_addr,
  output logic [IDW-1:0] resp_id,
  output logic           resp_l1_nocache,
  output logic           resp_l2_nocache
);

  localparam int RW     = IDW + FLAG_BITS;
  localparam int NLINES = 1 << AW;

  line_st_e       st [NLINES];
  logic           any_free, any_full, rp_valid;
  logic [AW-1:0]  rp_addr;
  logic [RW-1:0]  rp_data, in_data, cur_data;
  logic [AW-1:0]  cur_addr;
  logic           cur_go;
  logic [IDW-1:0] c_id;
  logic [1:0]     c_op;
  logic           c_full, c_l1b, c_sysb;
  act_e           act;
  line_st_e       nst;

  assign req_ready = !rp_valid && any_free && !any_full;
  assign in_data   = {req_id, req_op, req_full, req_l1_bypass, req_sys_bypass};
  assign cur_data  = rp_valid ? rp_data : in_data;
  assign cur_addr  = rp_valid ? rp_addr : req_addr;
  assign cur_go    = rp_valid || (req_valid && req_ready);
  assign {c_id, c_op, c_full, c_l1b, c_sysb} = cur_data;

  l2lc_decide u_decide (
    .op(c_op), .full(c_full), .sysb(c_sysb), .st(st[cur_addr]),
    .act(act), .nst(nst)
  );

  l2lc_line_tbl #(.AW(AW)) u_lines (
    .clk(clk), .rst(rst),
    .wr_en(cur_go && (act == ACT_RESP || act == ACT_WB)),
    .wr_addr(cur_addr), .wr_st(nst),
    .ack_en(wb_ack), .ack_addr(wb_ack_addr),
    .st_o(st)
  );

  l2lc_stall_buf #(.AW(AW), .NSLOT(NSLOT), .DEPTH(DEPTH), .RW(RW)) u_park (
    .clk(clk), .rst(rst),
    .lk_addr(req_addr), .any_free(any_free), .any_full(any_full),
    .push_en(!rp_valid && cur_go && (act == ACT_WB || act == ACT_PARK)),
    .push_data(in_data),
    .ack_en(wb_ack), .ack_addr(wb_ack_addr),
    .rp_valid(rp_valid), .rp_addr(rp_addr), .rp_data(rp_data),
    .rp_pop(rp_valid && act != ACT_WB && act != ACT_PARK),
    .rp_stop(rp_valid && act == ACT_WB)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0; fwd_valid <= 1'b0; resp_valid <= 1'b0;
      wb_addr <= '0; fwd_addr <= '0; fwd_id <= '0; fwd_op <= '0;
      resp_addr <= '0; resp_id <= '0;
      resp_l1_nocache <= 1'b0; resp_l2_nocache <= 1'b0;
    end else begin
      wb_valid   <= cur_go && act == ACT_WB;
      fwd_valid  <= cur_go && act == ACT_FWD;
      resp_valid <= cur_go && act == ACT_RESP;
      wb_addr    <= cur_addr;
      fwd_addr   <= cur_addr;
      fwd_id     <= c_id;
      fwd_op     <= c_op;
      resp_addr  <= cur_addr;
      resp_id    <= c_id;
      resp_l1_nocache <= c_l1b | c_sysb;
      resp_l2_nocache <= c_sysb;
    end
  end

  AST_WB_TARGET: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> st[wb_addr] == LN_WAITWB); // R3
  AST_FWD_CLEAN: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> st[fwd_addr] == LN_CLEAN); // R5
  AST_RESP_SETTLED: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> st[resp_addr] != LN_WAITWB); // R6
  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    $countones({wb_valid, fwd_valid, resp_valid}) <= 1); // R7

endmodule

// File: tb/tb_l2lc_ctrl.sv
module tb_l2lc_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 4, IDW = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_full = 0, req_l1_bypass = 0, req_sys_bypass = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0, wb_ack_addr = 0;
  logic [IDW-1:0] req_id = 0;
  logic wb_ack = 0;
  logic req_ready, wb_valid, fwd_valid, resp_valid, resp_l1_nocache, resp_l2_nocache;
  logic [AW-1:0] wb_addr, fwd_addr, resp_addr;
  logic [IDW-1:0] fwd_id, resp_id;
  logic [1:0] fwd_op;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  l2lc_ctrl #(.AW(AW), .IDW(IDW)) dut (.*);

  // kinds: 0 none, 1 response, 2 forward, 3 write-back, 7 several
  function automatic logic [31:0] obs();
    int k;
    k = int'(wb_valid) + int'(fwd_valid) + int'(resp_valid);
    if (k == 0) return 32'h0;
    if (k > 1) return 32'h07000000;
    if (resp_valid) return {8'd1, 4'd0, resp_addr, 4'd0, resp_id, 8'd0};
    if (fwd_valid) return {8'd2, 4'd0, fwd_addr, 4'd0, fwd_id, 6'd0, fwd_op};
    return {8'd3, 4'd0, wb_addr, 16'd0};
  endfunction

  function automatic logic [31:0] ex(int kind, int addr, int id, int op);
    if (kind == 0) return 32'h0;
    if (kind == 3) return {8'd3, 8'(addr), 16'd0};
    if (kind == 2) return {8'd2, 8'(addr), 8'(id), 8'(op)};
    return {8'd1, 8'(addr), 8'(id), 8'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_tests++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, a, e);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; step(); step(); rst = 0;
  endtask

  task automatic send(int op, int addr, int id, bit full, bit l1b, bit sysb);
    int guard = 0;
    while (!req_ready && guard < 50) begin step(); guard++; end
    req_valid = 1; req_op = 2'(op); req_addr = AW'(addr); req_id = IDW'(id);
    req_full = full; req_l1_bypass = l1b; req_sys_bypass = sysb;
    step();
    req_valid = 0;
  endtask

  task automatic ack(int addr);
    wb_ack = 1; wb_ack_addr = AW'(addr);
    step();
    wb_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 outputs idle", obs(), 32'h0);
    chk("R1 ready", 32'(req_ready), 32'd1);

    // sweep: start state s (0 clean,1 mod,2 dirty), op o (0 load,1 store full,2 store partial,3 atomic), flags f
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++)
        for (int f = 0; f < 4; f++) begin
          int a, opc, kind, lst, rk;
          bit l1b, sysb, down;
          a = (s * 16 + o * 4 + f) % 16;
          l1b = f[0]; sysb = f[1];
          do_reset();
          if (s == 1) begin send(1, a, 1, 1, 0, 0); chk("R11 store full resp", obs(), ex(1, a, 1, 0)); end
          if (s == 2) begin send(1, a, 1, 0, 0, 0); chk("R11 store partial resp", obs(), ex(1, a, 1, 0)); end
          opc = (o == 0) ? 0 : (o == 3) ? 2 : 1;
          down = (o == 3) || (opc == 1 && sysb);
          if (down) kind = (s == 0) ? 2 : 3;
          else if (o == 0) kind = (s == 2) ? 3 : 1;
          else kind = 1;
          lst = s;
          send(opc, a, 9, o == 1, l1b, sysb);
          chk(down ? "R4 atomic/bypass store" : (o == 0 ? "R2 R3 load" : "R11 store"),
              obs(), ex(kind, a, 9, opc));
          if (kind == 1) begin
            chk("R12 flags", {30'd0, resp_l1_nocache, resp_l2_nocache}, {30'd0, l1b | sysb, sysb});
            if (o == 1) lst = 1;
            if (o == 2) lst = 2;
          end
          if (kind == 3) begin
            for (int w = 0; w < 3; w++) begin step(); chk("R5 held before ack", obs(), 32'h0); end
            ack(a);
            chk("R7 ready low during replay", 32'(req_ready), 32'd0);
            step();
            rk = down ? 2 : 1;
            chk("R8 replay after ack", obs(), ex(rk, a, 9, opc));
            if (rk == 1)
              chk("R12 replay flags", {30'd0, resp_l1_nocache, resp_l2_nocache}, {30'd0, l1b | sysb, sysb});
            lst = 0;
          end
          step();
          send(0, a, 3, 0, 0, 0);
          chk("R4 R11 line state probe", obs(), ex(lst == 2 ? 3 : 1, a, 3, 0));
        end

    // R6 R7 R9: parking, order, re-dirty on replay
    do_reset();
    send(1, 5, 1, 0, 0, 0);
    send(0, 5, 2, 0, 0, 0);
    chk("R3 load on dirty", obs(), ex(3, 5, 0, 0));
    send(1, 5, 3, 0, 0, 0);
    chk("R6 parked store silent", obs(), 32'h0);
    send(0, 5, 4, 0, 0, 0);
    chk("R6 parked load silent", obs(), 32'h0);
    send(0, 6, 7, 0, 0, 0);
    chk("R2 other line unaffected", obs(), ex(1, 6, 7, 0));
    ack(5);
    chk("R7 ready low after ack", 32'(req_ready), 32'd0);
    step(); chk("R7 R8 first replay", obs(), ex(1, 5, 2, 0));
    step(); chk("R7 second replay", obs(), ex(1, 5, 3, 0));
    step(); chk("R9 re-dirty triggers wb", obs(), ex(3, 5, 0, 0));
    step(); chk("R9 replay stopped", obs(), 32'h0);
    chk("R9 ready after stop", 32'(req_ready), 32'd1);
    ack(5);
    step(); chk("R9 resumed replay", obs(), ex(1, 5, 4, 0));
    step(); chk("R7 drain done", 32'(req_ready), 32'd1);

    // R10 depth limit, R7 order across a full slot
    do_reset();
    send(1, 7, 1, 0, 0, 0);
    send(2, 7, 10, 0, 0, 0);
    chk("R4 atomic on dirty wb", obs(), ex(3, 7, 0, 0));
    for (int k = 0; k < 3; k++) send(0, 7, 11 + k, 0, 0, 0);
    chk("R10 depth full ready low", 32'(req_ready), 32'd0);
    ack(7);
    step(); chk("R8 atomic forwarded on replay", obs(), ex(2, 7, 10, 2));
    for (int k = 0; k < 3; k++) begin
      step(); chk("R7 depth replay order", obs(), ex(1, 7, 11 + k, 0));
    end
    step(); chk("R10 ready after drain", 32'(req_ready), 32'd1);

    // R10 all slots in use
    do_reset();
    for (int k = 0; k < 4; k++) begin
      send(1, k, 1, 0, 0, 0);
      send(0, k, 2 + k, 0, 0, 0);
      chk("R3 wb per slot", obs(), ex(3, k, 0, 0));
    end
    chk("R10 no free slot ready low", 32'(req_ready), 32'd0);
    ack(2);
    step(); chk("R8 replay of slot", obs(), ex(1, 2, 4, 0));
    step(); chk("R10 slot freed ready high", 32'(req_ready), 32'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule